// File: doc/BRIEF.md
# Asynchronous host-bus slave latch port

This block lets an external microprocessor treat one byte of a chip's pin bank as a peripheral register. The external master selects the port with an active-low chip-select. It deposits a byte with an active-low write strobe or collects a byte with an active-low read strobe. Neither strobe is related to the core clock. The strobes pass through a synchronizer, and an edge detector turns each access into a single-cycle event in the core clock domain.

On the core side, a synchronous interface loads the byte that the host will read and takes the byte that the host wrote. Four flags mark the handshake state: input full, output full, overflow, and an interrupt request raised on every host access. The port works only while a mode-enable input is high. When mode-enable is low, the strobes are ignored and the pins act as a plain output port whose driver is controlled by the core.

The byte on `bus_in` must stay stable from the falling strobe until the write is recognized, which takes three core clock cycles.

Top module: `hostbus_slave_port`

## Requirements
- R1: After reset, `in_full`, `out_full`, `overflow` and `irq` are 0, `core_rdata` and `bus_out` are 0x00, and `bus_oe` is 0.
- R2: While `mode_en`=1, a host write (`cs_n`=0 and `wr_n`=0) updates the core side on the third rising clock edge after the strobes fall, and not before. At that edge `core_rdata` takes the `bus_in` byte, `in_full` becomes 1 and `irq` becomes 1.
- R3: A host write recognized while `in_full` is 1 sets `overflow`, and the newer byte replaces the stored byte. `overflow` stays set until the core pulses `ovf_clr`.
- R4: A `core_take` pulse clears `in_full` on the next edge.
- R5: A `core_load` pulse puts `core_wdata` on `bus_out` and sets `out_full` on the next edge. A host read (`cs_n`=0 and `rd_n`=0) clears `out_full` and sets `irq` on the third rising edge after the strobes fall.
- R6: While `mode_en`=1, `bus_oe` is 1 exactly while `cs_n`=0 and `rd_n`=0, with no clock delay. During that time `bus_out` carries the byte the core loaded.
- R7: A strobe held low for many cycles counts as a single access. If `irq` is cleared during the hold, it stays 0 until the strobes go high and fall again.
- R8: While `mode_en`=0, the host strobes have no effect on any flag, and `bus_oe` follows `gp_oe`.
- R9: `irq` stays 1 until `irq_clr` is pulsed. When a host access and `irq_clr` land on the same edge, `irq` ends up 1.
- R10: With `cs_n`=1, low `wr_n` or `rd_n` changes no flag and leaves `bus_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | 1 = host slave mode, 0 = general output port |
| gp_oe | input | 1 | Pin driver enable used in general port mode |
| cs_n | input | 1 | Host chip-select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| bus_in | input | 8 | Byte seen on the pins |
| bus_out | output | 8 | Byte to drive onto the pins (the output latch) |
| bus_oe | output | 1 | Pin driver enable; 0 = high impedance |
| core_load | input | 1 | Core pulse: load `core_wdata` into the output latch |
| core_wdata | input | 8 | Byte to load into the output latch |
| core_take | input | 1 | Core pulse: the input byte has been consumed |
| core_rdata | output | 8 | Byte last written by the host |
| irq_clr | input | 1 | Core pulse: clear `irq` |
| ovf_clr | input | 1 | Core pulse: clear `overflow` |
| in_full | output | 1 | Host has written a byte not yet taken |
| out_full | output | 1 | Core has loaded a byte not yet read by the host |
| overflow | output | 1 | A host write arrived while `in_full` was set |
| irq | output | 1 | Sticky host-access interrupt request |

## Verification
The assertions check every cycle that each recognized access lasts one cycle, that each access event moves the flags it owns on the next edge, that a core pulse clears or sets its flag, and that a sticky flag holds until it is cleared. They also check that no access is recognized while the mode is off and that the pin driver is on only under an active read select. The exact three-edge latency, the data that is captured, the single count during a long hold, the set-over-clear priority and the inertness of strobes without chip-select are shown only by the bench's directed scenarios, which compare the ports against values worked out from the requirements.

// File: rtl/hbsp_pkg.sv
// Package for the host-bus slave port: shared widths and lane indices.
// Assumes: exactly two access lanes (host write, host read).
package hbsp_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_LANES = 2;

    typedef enum int {
        LANE_WR = 0,
        LANE_RD = 1
    } lane_e;
endpackage

// File: rtl/hbsp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous level inputs.
// Assumes: each bit is an independent level; the reset value is the inactive level.
module hbsp_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbsp_edge.sv
// Rising-edge detector on active-high access terms, one lane per access kind.
// Assumes: inputs are already synchronous to clk; the output pulse lasts one cycle.
module hbsp_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] act,
    output logic [N-1:0] pulse
);
    logic [N-1:0] prev_q;

    // Remember the previous level of each access term.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= act;
    end

    assign pulse = act & ~prev_q;
endmodule

// File: rtl/hbsp_regs.sv
// Data latches and handshake flags of the host-bus slave port.
// Assumes: access pulses last one cycle; when a set and a clear land on the same edge, the set wins.
module hbsp_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_pulse,
    input  logic         rd_pulse,
    input  logic [W-1:0] bus_in,
    input  logic         core_load,
    input  logic [W-1:0] core_wdata,
    input  logic         core_take,
    input  logic         irq_clr,
    input  logic         ovf_clr,
    output logic [W-1:0] in_latch,
    output logic [W-1:0] out_latch,
    output logic         in_full,
    output logic         out_full,
    output logic         overflow,
    output logic         irq
);
    // Capture the host byte on a recognized host write.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_latch <= '0;
        else if (wr_pulse) in_latch <= bus_in;
    end

    // Hold the byte the core offers to the host.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_latch <= '0;
        else if (core_load) out_latch <= core_wdata;
    end

    // Input-full: set by a host write, cleared when the core takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         in_full <= 1'b0;
        else if (wr_pulse)  in_full <= 1'b1;
        else if (core_take) in_full <= 1'b0;
    end

    // Output-full: set by a core load, cleared by a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_full <= 1'b0;
        else if (core_load) out_full <= 1'b1;
        else if (rd_pulse)  out_full <= 1'b0;
    end

    // Overflow: a host write arrives while the previous byte is still pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                   overflow <= 1'b0;
        else if (wr_pulse && in_full) overflow <= 1'b1;
        else if (ovf_clr)             overflow <= 1'b0;
    end

    // Sticky interrupt on every host access, cleared only by the core.
    always_ff @(posedge clk) begin
        if (!rst_n)                    irq <= 1'b0;
        else if (wr_pulse || rd_pulse) irq <= 1'b1;
        else if (irq_clr)              irq <= 1'b0;
    end
endmodule

// File: rtl/hostbus_slave_port.sv
// Top of the host-bus slave port: gates and synchronizes the host strobes,
// detects access edges, holds the latches and flags, and controls the pin driver.
// Assumes: bus_in is stable from the falling write strobe until the write is recognized.
module hostbus_slave_port
    import hbsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              gp_oe,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              core_load,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_take,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic              in_full,
    output logic              out_full,
    output logic              overflow,
    output logic              irq
);
    logic [2:0]           gated;
    logic [2:0]           synced;
    logic                 s_cs_n, s_wr_n, s_rd_n;
    logic [NUM_LANES-1:0] act;
    logic [NUM_LANES-1:0] pulse;
    logic                 wr_pulse, rd_pulse;

    // Strobes reach the core only in slave mode; otherwise they look idle (high).
    assign gated = mode_en ? {cs_n, wr_n, rd_n} : 3'b111;

    hbsp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (gated),
        .q    (synced)
    );

    assign {s_cs_n, s_wr_n, s_rd_n} = synced;

    // Combined access terms per lane.
    always_comb begin
        act          = '0;
        act[LANE_WR] = mode_en & ~s_cs_n & ~s_wr_n;
        act[LANE_RD] = mode_en & ~s_cs_n & ~s_rd_n;
    end

    hbsp_edge #(.N(NUM_LANES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .act  (act),
        .pulse(pulse)
    );

    assign wr_pulse = pulse[LANE_WR];
    assign rd_pulse = pulse[LANE_RD];

    hbsp_regs #(.W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pulse  (wr_pulse),
        .rd_pulse  (rd_pulse),
        .bus_in    (bus_in),
        .core_load (core_load),
        .core_wdata(core_wdata),
        .core_take (core_take),
        .irq_clr   (irq_clr),
        .ovf_clr   (ovf_clr),
        .in_latch  (core_rdata),
        .out_latch (bus_out),
        .in_full   (in_full),
        .out_full  (out_full),
        .overflow  (overflow),
        .irq       (irq)
    );

    // Pin driver: asynchronous read select in slave mode, core control otherwise.
    assign bus_oe = mode_en ? (~cs_n & ~rd_n) : gp_oe;
endmodule

// File: rtl/hbsp_checker.sv
// Property checker for hostbus_slave_port, attached with bind below.
// Assumes: clocked checks are disabled while rst_n is low.
module hbsp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_en,
    input logic       cs_n,
    input logic       rd_n,
    input logic       core_load,
    input logic [7:0] core_wdata,
    input logic       core_take,
    input logic       ovf_clr,
    input logic       irq_clr,
    input logic [7:0] bus_out,
    input logic       bus_oe,
    input logic       in_full,
    input logic       out_full,
    input logic       overflow,
    input logic       irq,
    input logic       wr_pulse,
    input logic       rd_pulse
);
    a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> (in_full && irq));

    a_r3_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && in_full) |=> overflow);

    a_r3_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);

    a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (core_take && !wr_pulse) |=> !in_full);

    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |=> (out_full && bus_out == $past(core_wdata)));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && !core_load) |=> (!out_full && irq));

    a_r6_oe_select: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && bus_oe) |-> (!cs_n && !rd_n));

    a_r7_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);

    a_r8_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> (!wr_pulse && !rd_pulse));

    a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

bind hostbus_slave_port hbsp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .core_load (core_load),
    .core_wdata(core_wdata),
    .core_take (core_take),
    .ovf_clr   (ovf_clr),
    .irq_clr   (irq_clr),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .in_full   (in_full),
    .out_full  (out_full),
    .overflow  (overflow),
    .irq       (irq),
    .wr_pulse  (wr_pulse),
    .rd_pulse  (rd_pulse)
);

// File: tb/hostbus_slave_port_bench.sv
// Directed bench for hostbus_slave_port: one task per scenario, each checking its own results.
module hostbus_slave_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b0, gp_oe = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] bus_in = '0, bus_out, core_wdata = '0, core_rdata;
    logic       bus_oe, core_load = 1'b0, core_take = 1'b0;
    logic       irq_clr = 1'b0, ovf_clr = 1'b0;
    logic       in_full, out_full, overflow, irq;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_slave_port u_hostbus_slave_port (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .gp_oe(gp_oe),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .core_load(core_load),
        .core_wdata(core_wdata), .core_take(core_take), .core_rdata(core_rdata),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .in_full(in_full),
        .out_full(out_full), .overflow(overflow), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_core(input int which);
        @(negedge clk);
        case (which)
            0: core_take = 1'b1;
            1: irq_clr   = 1'b1;
            default: ovf_clr = 1'b1;
        endcase
        @(negedge clk);
        core_take = 1'b0; irq_clr = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic load(input logic [7:0] v);
        @(negedge clk);
        core_load = 1'b1; core_wdata = v;
        @(negedge clk);
        core_load = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk);
        bus_in = v; cs_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 in_full", in_full, 0);
        check("R1 out_full", out_full, 0);
        check("R1 overflow", overflow, 0);
        check("R1 irq", irq, 0);
        check("R1 rdata", core_rdata, 8'h00);
        check("R1 bus_out", bus_out, 8'h00);
        check("R1 bus_oe", bus_oe, 0);
    endtask

    task automatic t_write;
        @(negedge clk);
        bus_in = 8'hA5; cs_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 early in_full", in_full, 0);
        @(negedge clk);
        check("R2 in_full", in_full, 1);
        check("R2 rdata", core_rdata, 8'hA5);
        check("R2 irq", irq, 1);
        check("R2 overflow stays", overflow, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_take;
        pulse_core(0);
        check("R4 in_full cleared", in_full, 0);
        check("R4 rdata kept", core_rdata, 8'hA5);
        pulse_core(1);
        check("R9 irq cleared", irq, 0);
    endtask

    task automatic t_overflow;
        host_write(8'h3C);
        check("R3 no overflow first", overflow, 0);
        host_write(8'hC3);
        check("R3 overflow", overflow, 1);
        check("R3 newest byte", core_rdata, 8'hC3);
        repeat (4) @(negedge clk);
        check("R3 overflow sticky", overflow, 1);
        pulse_core(2);
        check("R3 overflow cleared", overflow, 0);
        pulse_core(0);
        pulse_core(1);
    endtask

    task automatic t_host_read;
        load(8'h5A);
        check("R5 out_full", out_full, 1);
        check("R5 bus_out", bus_out, 8'h5A);
        check("R6 oe idle", bus_oe, 0);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        check("R6 oe immediate", bus_oe, 1);
        check("R6 data driven", bus_out, 8'h5A);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R5 early out_full", out_full, 1);
        @(negedge clk);
        check("R5 out_full cleared", out_full, 0);
        check("R5 irq", irq, 1);
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
        check("R6 oe released", bus_oe, 0);
        repeat (3) @(negedge clk);
        pulse_core(1);
    endtask

    task automatic t_hold;
        @(negedge clk);
        bus_in = 8'h11; cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 irq during hold", irq, 1);
        irq_clr = 1'b1; core_take = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0; core_take = 1'b0;
        repeat (8) @(negedge clk);
        check("R7 irq once", irq, 0);
        check("R7 in_full once", in_full, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_cs_high;
        @(negedge clk);
        wr_n = 1'b0; rd_n = 1'b0;
        #1;
        check("R10 oe", bus_oe, 0);
        repeat (6) @(negedge clk);
        check("R10 in_full", in_full, 0);
        check("R10 irq", irq, 0);
        check("R10 out_full", out_full, 0);
        wr_n = 1'b1; rd_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_irq_priority;
        @(negedge clk);
        irq_clr = 1'b1; bus_in = 8'h77; cs_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 irq before access", irq, 0);
        @(negedge clk);
        check("R9 set wins", irq, 1);
        irq_clr = 1'b0; cs_n = 1'b1; wr_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 irq kept", irq, 1);
        pulse_core(0);
        pulse_core(1);
    endtask

    task automatic t_mode_off;
        load(8'h96);
        @(negedge clk);
        mode_en = 1'b0;
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0;
        #1;
        check("R8 oe follows gp_oe low", bus_oe, 0);
        repeat (6) @(negedge clk);
        check("R8 in_full", in_full, 0);
        check("R8 irq", irq, 0);
        check("R8 out_full kept", out_full, 1);
        gp_oe = 1'b1;
        #1;
        check("R8 oe follows gp_oe high", bus_oe, 1);
        check("R8 bus_out", bus_out, 8'h96);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; gp_oe = 1'b0;
        @(negedge clk);
        mode_en = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        mode_en = 1'b1;
        repeat (2) @(negedge clk);
        t_write();
        t_take();
        t_overflow();
        t_host_read();
        t_hold();
        t_cs_high();
        t_irq_priority();
        t_mode_off();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule